// File: doc/BRIEF.md
# Serial Slave Front End with Per-Transaction Clock Polarity Detection

This block is the bit-level receive and transmit stage of a serial memory slave. It sits between the chip-select, serial-clock and serial-data pins and the command logic behind it. All three inputs pass through synchronisers into a faster system clock. Every pin edge is then found by edge detection in that clock domain, so the whole block runs on the system clock.

The block has no fixed clock-polarity setting. Each time chip select falls, it samples the idle serial-clock level. A high level selects Mode 3 and a low level selects Mode 0. That choice holds until chip select rises again.

Incoming bits are sampled on serial-clock rising edges, MSB first, and collected into bytes. Each complete byte is presented with a one-cycle strobe. Outgoing bits come from a byte supplied by the command logic. They change on serial-clock falling edges and leave the block through a data output and an output enable, which an external tristate buffer uses to drive the pin.

Top module: `spi_auto_mode_fe`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after reset, `mode3` is 1 (Mode 3 is the default), `so_oe` is 0 and `rx_valid` is 0.
- R2: `so_oe` is 0 whenever chip select is high, so the output pin is high impedance while the slave is not selected. `so_oe` is 1 only during a transaction that began with a chip-select falling edge.
- R3: A transaction starts only on a high-to-low transition of `cs_n_in` seen after reset. If `cs_n_in` is already low when reset is released, `so_oe` stays 0 and no byte strobe fires until `cs_n_in` goes high and then low again.
- R4: On each chip-select falling edge, the level of `sck_in` is latched into `mode3`: 1 means Mode 3 (clock idles high) and 0 means Mode 0 (clock idles low). `mode3` does not change while the slave stays selected.
- R5: `si_in` is sampled on each rising edge of `sck_in` while the slave is selected. The first sampled bit becomes bit 7 of `rx_byte`. After eight bits, the byte appears on `rx_byte` together with `rx_valid`.
- R6: `rx_valid` is high for exactly one system-clock cycle per received byte.
- R7: `so_out` changes only on falling edges of `sck_in`, MSB first. `tx_byte` is captured when chip select falls, so in Mode 0 bit 7 is already present before the first rising edge. `tx_byte` is captured again on the first falling edge after each byte boundary, so in Mode 3 that first falling edge presents bit 7. Every later falling edge presents the next lower bit.
- R8: When chip select rises, the bit counter clears. A partial byte is discarded without a strobe, and the next transaction starts again at bit 7.
- R9: While reset is held, serial-clock edges, data and chip-select activity have no effect. No strobe fires and the output stays disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_in | input | 1 | Asynchronous active-low chip select pin |
| sck_in | input | 1 | Asynchronous serial clock pin |
| si_in | input | 1 | Asynchronous serial data input pin |
| tx_byte | input | W | Byte to shift out, MSB first |
| so_out | output | 1 | Serial data output value |
| so_oe | output | 1 | Output enable for the external tristate buffer |
| rx_byte | output | W | Last byte received |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_byte` |
| mode3 | output | 1 | Mode of the current or last transaction (1 = Mode 3) |

## Verification
The bound checker watches four things on every cycle:
- the reset values;
- that the output enable stays low once chip select has been high for three cycles;
- that the byte strobe is a single pulse and only fires while the slave is selected;
- that the latched mode holds steady for the whole transaction.

Only the bench's scenarios can show the following:
- the order of the received data bits;
- the transmitted bit sequence, including which edge first presents bit 7 in each mode;
- that a partial byte is discarded;
- that a chip select already low at reset release is refused;
- that activity during reset is ignored.

The bench checks these with a scoreboard of expected bytes and with output samples taken just before each rising edge of the serial clock.

// File: rtl/spi_af_pkg.sv
package spi_af_pkg;
  typedef enum logic {
    MODE_0 = 1'b0,
    MODE_3 = 1'b1
  } spi_mode_e;

  localparam int unsigned PIN_COUNT = 3;
  localparam int unsigned PIN_CS    = 2;
  localparam int unsigned PIN_SCK   = 1;
  localparam int unsigned PIN_SI    = 0;
endpackage

// File: rtl/spi_af_sync.sv
module spi_af_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage[g] <= '0;
        end else begin
          if (g == 0) stage[g] <= d;
          else        stage[g] <= stage[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_af_edges.sv
module spi_af_edges (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic sck_s,
  output logic cs_fall,
  output logic sck_rise,
  output logic sck_fall
);
  // The previous-value registers reset to 0. A chip select that is already
  // low when reset is released therefore never looks like a falling edge.
  logic cs_d, sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d  <= 1'b0;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign cs_fall  =  cs_d  & ~cs_s;
  assign sck_rise = ~sck_d &  sck_s;
  assign sck_fall =  sck_d & ~sck_s;
endmodule

// File: rtl/spi_af_rx.sv
module spi_af_rx #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         active,
  input  logic         sck_rise,
  input  logic         si,
  output logic [W-1:0] rx_byte,
  output logic         rx_valid,
  output logic         cnt_zero
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  sr;
  logic [W-1:0]  sr_next;

  assign sr_next = {sr[W-2:0], si};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sr       <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (clear) begin
        cnt <= '0;
      end else if (active && sck_rise) begin
        sr <= sr_next;
        if (cnt == LAST) begin
          cnt      <= '0;
          rx_byte  <= sr_next;
          rx_valid <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign cnt_zero = (cnt == '0);
endmodule

// File: rtl/spi_af_tx.sv
module spi_af_tx #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_start,
  input  logic         active,
  input  logic         sck_fall,
  input  logic         cnt_zero,
  input  logic [W-1:0] tx_byte,
  output logic         so_bit
);
  logic [W-1:0] sr;

  // A falling edge at a byte boundary reloads the shift register, so the
  // next MSB appears. Every other falling edge moves on to the next bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (load_start) begin
      sr <= tx_byte;
    end else if (active && sck_fall) begin
      if (cnt_zero) sr <= tx_byte;
      else          sr <= {sr[W-2:0], 1'b0};
    end
  end

  assign so_bit = sr[W-1];
endmodule

// File: rtl/spi_auto_mode_fe.sv
module spi_auto_mode_fe
  import spi_af_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n_in,
  input  logic         sck_in,
  input  logic         si_in,
  input  logic [W-1:0] tx_byte,
  output logic         so_out,
  output logic         so_oe,
  output logic [W-1:0] rx_byte,
  output logic         rx_valid,
  output logic         mode3
);
  logic [PIN_COUNT-1:0] pins_raw, pins_s;
  logic cs_s, sck_s, si_s;
  logic cs_fall, sck_rise, sck_fall;
  logic selected, active, cnt_zero, so_bit;
  spi_mode_e mode_q;

  assign pins_raw[PIN_CS]  = cs_n_in;
  assign pins_raw[PIN_SCK] = sck_in;
  assign pins_raw[PIN_SI]  = si_in;

  spi_af_sync #(.N(PIN_COUNT), .STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_s)
  );

  assign cs_s  = pins_s[PIN_CS];
  assign sck_s = pins_s[PIN_SCK];
  assign si_s  = pins_s[PIN_SI];

  spi_af_edges u_edges (
    .clk      (clk),
    .rst      (rst),
    .cs_s     (cs_s),
    .sck_s    (sck_s),
    .cs_fall  (cs_fall),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
  );

  // Selection state and per-transaction mode capture.
  always_ff @(posedge clk) begin
    if (rst) begin
      selected <= 1'b0;
      mode_q   <= MODE_3;
    end else if (cs_s) begin
      selected <= 1'b0;
    end else if (cs_fall) begin
      selected <= 1'b1;
      mode_q   <= sck_s ? MODE_3 : MODE_0;
    end
  end

  assign active = selected & ~cs_s;

  spi_af_rx #(.W(W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .clear    (cs_s),
    .active   (active),
    .sck_rise (sck_rise),
    .si       (si_s),
    .rx_byte  (rx_byte),
    .rx_valid (rx_valid),
    .cnt_zero (cnt_zero)
  );

  spi_af_tx #(.W(W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .load_start (cs_fall),
    .active     (active),
    .sck_fall   (sck_fall),
    .cnt_zero   (cnt_zero),
    .tx_byte    (tx_byte),
    .so_bit     (so_bit)
  );

  assign so_oe  = selected;
  assign so_out = selected & so_bit;
  assign mode3  = (mode_q == MODE_3);
endmodule

// File: rtl/spi_af_chk.sv
module spi_af_chk (
  input logic clk,
  input logic rst,
  input logic cs_n_in,
  input logic so_oe,
  input logic rx_valid,
  input logic mode3
);
  // R1: defaults visible in the first cycle after reset
  a_r1_reset_defaults: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode3 && !so_oe && !rx_valid));

  // R2: chip select high for three cycles leaves the output disabled
  a_r2_hiz_deselected: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n_in) && $past(cs_n_in, 2) && $past(cs_n_in, 3)) |-> !so_oe);

  // R4: the latched mode holds for the whole transaction
  a_r4_mode_held: assert property (@(posedge clk) disable iff (rst)
    (so_oe && $past(so_oe)) |-> $stable(mode3));

  // R5: a byte strobe fires only inside a transaction
  a_r5_strobe_selected: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> so_oe);

  // R6: the strobe lasts a single cycle
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

bind spi_auto_mode_fe spi_af_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n_in  (cs_n_in),
  .so_oe    (so_oe),
  .rx_valid (rx_valid),
  .mode3    (mode3)
);

// File: tb/spi_auto_mode_fe_tb_top.sv
`timescale 1ns/1ps
module spi_auto_mode_fe_tb_top;
  localparam int W = 8;
  localparam int H = 4;  // half serial-clock period, in system clocks

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cs_n_in = 1'b1;
  logic         sck_in = 1'b0;
  logic         si_in = 1'b0;
  logic [W-1:0] tx_byte = '0;
  logic         so_out, so_oe, rx_valid, mode3;
  logic [W-1:0] rx_byte;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit prev_v = 1'b0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] mo [8];
  logic [W-1:0] mi [8];

  always #2.5 clk = ~clk;

  spi_auto_mode_fe #(.W(W)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .cs_n_in  (cs_n_in),
    .sck_in   (sck_in),
    .si_in    (si_in),
    .tx_byte  (tx_byte),
    .so_out   (so_out),
    .so_oe    (so_oe),
    .rx_byte  (rx_byte),
    .rx_valid (rx_valid),
    .mode3    (mode3)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: every strobe must match the next expected byte.
  always @(negedge clk) begin
    if (rx_valid === 1'b1) begin
      chk(!prev_v, "R6 strobe width", 32'(prev_v), 0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5/R8 unexpected strobe", 32'(rx_byte), 0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(rx_byte == e, "R5 received byte", 32'(rx_byte), 32'(e));
      end
    end
    prev_v = (rx_valid === 1'b1);
  end

  // Driver: one transaction of nbits bits in the given mode.
  task automatic xfer(input bit m3, input int nbits);
    sck_in = m3;
    wclk(H);
    tx_byte = mi[0];
    wclk(2);
    cs_n_in = 1'b0;
    wclk(H);
    chk(mode3 == m3, "R4 mode latch", 32'(mode3), 32'(m3));
    for (int i = 0; i < nbits; i++) begin
      int byt;
      int bp;
      byt = i / 8;
      bp  = 7 - (i % 8);
      if (i % 8 == 0) tx_byte = mi[byt];
      sck_in = 1'b0;
      si_in  = mo[byt][bp];
      wclk(H);
      chk(so_oe == 1'b1, "R2 enable in transaction", 32'(so_oe), 1);
      chk(so_out == mi[byt][bp], "R7 output bit", 32'(so_out), 32'(mi[byt][bp]));
      if (i % 8 == 7) exp_q.push_back(mo[byt]);
      sck_in = 1'b1;
      wclk(H);
    end
    if (!m3) begin
      sck_in = 1'b0;
      wclk(H);
    end
    cs_n_in = 1'b1;
    wclk(H);
    chk(so_oe == 1'b0, "R2 disable after deselect", 32'(so_oe), 0);
  endtask

  task automatic toggle_bits(input int n);
    for (int i = 0; i < n; i++) begin
      sck_in = 1'b0; si_in = i[0]; wclk(H);
      sck_in = 1'b1; wclk(H);
    end
  endtask

  initial begin
    wclk(6);
    rst = 1'b0;
    @(negedge clk);
    chk(mode3 == 1'b1, "R1 default mode", 32'(mode3), 1);
    chk(so_oe == 1'b0, "R1 output disabled", 32'(so_oe), 0);
    chk(rx_valid == 1'b0, "R1 no strobe", 32'(rx_valid), 0);

    // R5 R7: Mode 0, two bytes
    mo[0] = 8'hA5; mo[1] = 8'h3C; mi[0] = 8'h96; mi[1] = 8'hC1;
    xfer(1'b0, 16);
    // R4 R7: Mode 3, three bytes including all-zero and all-one patterns
    mo[0] = 8'h00; mo[1] = 8'hFF; mo[2] = 8'h5A;
    mi[0] = 8'hFF; mi[1] = 8'h00; mi[2] = 8'h81;
    xfer(1'b1, 24);
    // R8: partial byte discarded, then a full byte starts at bit 7
    mo[0] = 8'hE7; mi[0] = 8'h4B;
    xfer(1'b0, 5);
    mo[0] = 8'h12; mi[0] = 8'hED;
    xfer(1'b1, 8);
    chk(exp_q.size() == 0, "R8 scoreboard drained", 32'(exp_q.size()), 0);

    // R3: chip select already low when reset is released
    rst = 1'b1; wclk(3);
    cs_n_in = 1'b0; sck_in = 1'b0; wclk(3);
    rst = 1'b0; wclk(H);
    toggle_bits(8);
    wclk(H);
    chk(so_oe == 1'b0, "R3 no start without falling edge", 32'(so_oe), 0);
    cs_n_in = 1'b1; wclk(H);
    mo[0] = 8'h69; mi[0] = 8'h3E;
    xfer(1'b0, 8);

    // R9: activity while reset is held
    rst = 1'b1; wclk(2);
    sck_in = 1'b0; wclk(H);
    cs_n_in = 1'b0; wclk(H);
    toggle_bits(8);
    wclk(H);
    chk(so_oe == 1'b0, "R9 output held off in reset", 32'(so_oe), 0);
    cs_n_in = 1'b1; wclk(H);
    rst = 1'b0;
    @(negedge clk);
    chk(mode3 == 1'b1, "R9 mode default after reset", 32'(mode3), 1);
    mo[0] = 8'hC3; mi[0] = 8'h7A;
    xfer(1'b1, 8);

    wclk(10);
    chk(exp_q.size() == 0, "R5 all bytes received", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule